// File: doc/BRIEF.md
# Credit-Gated Configuration Block Streamer

This block carries a configuration image from a byte stream into a 32-bit data register, one word per write. Incoming bytes are packed little-endian into words. Words are grouped into blocks: 4 bytes per block in legacy mode and `BLK_BYTES` bytes per block in credit mode. In credit mode, every block must first be granted. The grant comes from an 8-bit credit value that the target exposes. That value is compared with the low byte of a local count of blocks already written. A block may start only when the two bytes differ.

While a block waits for credit, the streamer re-reads the credit value every `POLL_CYCLES` clocks. On each read that finds no credit, it also looks at the target's configuration-error flag. It aborts when that flag is set, or when `MAX_POLLS` reads in a row have found no credit. An optional mode also samples the error flag at every `CHK_BYTES` boundary of the image and once more after the last byte.

A session begins with a `start` pulse while the block is idle. It ends with either a `done` pulse, which carries the total byte count, or an `err_valid` pulse with a code that tells the two failure causes apart.

Top module: `cfg_block_streamer`

## Requirements
- R1: A `start` pulse in idle clears the sent-block count. In credit mode, no byte is accepted (`in_ready` low) until `credit_val` differs from the low 8 bits of that count.
- R2: In credit mode, a block ends after `BLK_BYTES` accepted bytes or at the byte flagged `in_last`. The count then rises by one, and the next block is gated on the new low byte, which wraps modulo 256. With `credit_val` fixed at 0, block number 256 stalls.
- R3: In legacy mode (`credit_mode`=0 at start), credit is never consulted. `in_ready` stays high from the cycle after `start` until the last byte is accepted.
- R4: Bytes are packed little-endian: the first byte of each word lands in bits 7:0 and the fourth in bits 31:24. `wr_valid` pulses for one cycle, in the cycle after the byte that completes a word is accepted.
- R5: A final word holding 1 to 3 valid bytes is written with every unused upper byte equal to zero.
- R6: During a stall, a credit read happens on the first stalled cycle and then every `POLL_CYCLES` cycles. If a read finds no credit while `cfg_err` is high, the session aborts with `err_code`=2.
- R7: If `MAX_POLLS` consecutive reads find no credit and `cfg_err` is low, the session aborts with `err_code`=1. This happens on the `MAX_POLLS`-th read, `(MAX_POLLS-1)*POLL_CYCLES` cycles after the stall began.
- R8: When `chk_en` is high at start, `cfg_err` is sampled at each block end where the total byte count becomes a multiple of `CHK_BYTES`, and once after the last byte. If it is high at any of those samples, the session aborts with `err_code`=2 instead of finishing.
- R9: When `chk_en` is low, `cfg_err` has no effect outside a credit stall. `done` pulses one cycle after the last byte is accepted, with `done_bytes` equal to the number of image bytes.
- R10: `done` and `err_valid` are single-cycle pulses, never both high at once. After reset, and after either pulse, `in_ready` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a session when idle |
| credit_mode | input | 1 | Latched at start: 1 = credit-gated blocks, 0 = legacy 4-byte blocks |
| chk_en | input | 1 | Latched at start: enables boundary and end error sampling |
| in_valid | input | 1 | Image byte valid |
| in_data | input | 8 | Image byte |
| in_last | input | 1 | Marks the final image byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| credit_val | input | 8 | Current credit byte from the target |
| cfg_err | input | 1 | Configuration-error flag from the target |
| wr_valid | output | 1 | One-cycle data-register write strobe |
| wr_data | output | 32 | Word to write |
| done | output | 1 | Session finished cleanly (pulse) |
| done_bytes | output | 32 | Total bytes accepted in the session |
| err_valid | output | 1 | Session aborted (pulse) |
| err_code | output | 2 | 1 = credit timeout, 2 = configuration error |

## Verification
A block counter that is wrong or fails to wrap shows up at the ports as a stall in the wrong place. With a fixed credit byte, the number of bytes accepted before the stall pins the count down exactly. A poll timer that is off by a cycle moves the timeout pulse outside a window of a few cycles. Packing or masking faults corrupt `wr_data` on the very next write strobe. Every strobe is compared against words computed from the image. A missed error sample turns an expected abort into `done` within one cycle of the relevant block end.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int WORD_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATE,
    ST_XFER,
    ST_BCHK,
    ST_FIN
  } cbs_state_e;

  typedef enum logic [1:0] {
    EC_NONE    = 2'd0,
    EC_TIMEOUT = 2'd1,
    EC_CFGERR  = 2'd2
  } cbs_ecode_e;
endpackage

// File: rtl/cbs_credit_gate.sv
module cbs_credit_gate #(
  parameter int POLL_CYCLES = 1000,
  parameter int MAX_POLLS   = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [7:0] credit_val,
  input  logic [7:0] sent_lo,
  input  logic       cfg_err,
  output logic       grant,
  output logic       cfg_fail,
  output logic       timeout
);
  localparam int TW = $clog2(POLL_CYCLES + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [TW-1:0] TMR_RELOAD = TW'(POLL_CYCLES - 1);
  localparam logic [PW-1:0] LAST_POLL  = PW'(MAX_POLLS - 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic [PW-1:0] polls_q, polls_d;
  logic          rd, starved, tick_en;

  // A read happens whenever the interval timer has run out.
  assign rd       = active && (tmr_q == '0);
  assign starved  = rd && (credit_val == sent_lo);
  assign grant    = rd && (credit_val != sent_lo);
  assign cfg_fail = starved && cfg_err;
  assign timeout  = starved && !cfg_err && (polls_q == LAST_POLL);

  assign tick_en  = active || (tmr_q != '0) || (polls_q != '0);

  always_comb begin
    tmr_d   = tmr_q;
    polls_d = polls_q;
    if (!active) begin
      tmr_d   = '0;
      polls_d = '0;
    end else if (rd) begin
      tmr_d   = TMR_RELOAD;
      polls_d = polls_q + 1'b1;
    end else begin
      tmr_d   = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      polls_q <= '0;
    end else if (tick_en) begin
      tmr_q   <= tmr_d;
      polls_q <= polls_d;
    end
  end
endmodule

// File: rtl/cbs_packer.sv
module cbs_packer #(
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    accept,
  input  logic                    flush,
  input  logic [7:0]              byte_in,
  output logic                    lane_last,
  output logic                    wr_valid,
  output logic [WORD_BYTES*8-1:0] wr_data
);
  localparam int LW = $clog2(WORD_BYTES);
  localparam int DW = WORD_BYTES * 8;

  logic [LW-1:0] lane_q, lane_d;
  logic [DW-1:0] acc_q, acc_d, merged, masked;
  logic          wv_d, load_word, acc_en;

  assign lane_last = (lane_q == LW'(WORD_BYTES - 1));

  // Drop the incoming byte into its lane; lanes past it are forced to zero.
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    assign merged[8*k +: 8] = (accept && (lane_q == LW'(k))) ? byte_in : acc_q[8*k +: 8];
    assign masked[8*k +: 8] = (LW'(k) <= lane_q) ? merged[8*k +: 8] : 8'h00;
  end

  assign load_word = accept && flush;
  assign acc_en    = clear || accept;

  always_comb begin
    lane_d = lane_q;
    acc_d  = acc_q;
    wv_d   = 1'b0;
    if (clear) begin
      lane_d = '0;
      acc_d  = '0;
    end else if (load_word) begin
      lane_d = '0;
      acc_d  = '0;
      wv_d   = 1'b1;
    end else if (accept) begin
      lane_d = lane_q + 1'b1;
      acc_d  = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q   <= '0;
      acc_q    <= '0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_valid <= wv_d;
      if (acc_en) begin
        lane_q <= lane_d;
        acc_q  <= acc_d;
      end
      if (load_word && !clear) begin
        wr_data <= masked;
      end
    end
  end
endmodule

// File: rtl/cbs_blk_track.sv
module cbs_blk_track #(
  parameter int BLK_BYTES  = 4096,
  parameter int CHK_BYTES  = 4096,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             accept,
  input  logic             last,
  input  logic             legacy,
  output logic             blk_end,
  output logic             chk_hit,
  output logic [CNT_W-1:0] sent_cnt,
  output logic [CNT_W-1:0] total
);
  localparam int BW = $clog2(BLK_BYTES);
  localparam int CW = $clog2(CHK_BYTES);

  logic [BW-1:0]    blk_q, blk_d, limit;
  logic [CNT_W-1:0] sent_d, total_d, total_inc;
  logic             upd_en;

  assign limit     = legacy ? BW'(WORD_BYTES - 1) : BW'(BLK_BYTES - 1);
  assign total_inc = total + 1'b1;
  assign blk_end   = accept && (last || (blk_q == limit));
  assign chk_hit   = blk_end && (total_inc[CW-1:0] == '0);
  assign upd_en    = clear || accept;

  always_comb begin
    blk_d   = blk_q;
    sent_d  = sent_cnt;
    total_d = total;
    if (clear) begin
      blk_d   = '0;
      sent_d  = '0;
      total_d = '0;
    end else if (accept) begin
      total_d = total_inc;
      blk_d   = blk_end ? '0 : blk_q + 1'b1;
      sent_d  = blk_end ? sent_cnt + 1'b1 : sent_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q    <= '0;
      sent_cnt <= '0;
      total    <= '0;
    end else if (upd_en) begin
      blk_q    <= blk_d;
      sent_cnt <= sent_d;
      total    <= total_d;
    end
  end
endmodule

// File: rtl/cfg_block_streamer.sv
module cfg_block_streamer
  import cbs_pkg::*;
#(
  parameter int BLK_BYTES   = 4096,
  parameter int POLL_CYCLES = 1000,
  parameter int MAX_POLLS   = 2000,
  parameter int CHK_BYTES   = 4096,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             credit_mode,
  input  logic             chk_en,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  input  logic [7:0]       credit_val,
  input  logic             cfg_err,
  output logic             wr_valid,
  output logic [31:0]      wr_data,
  output logic             done,
  output logic [CNT_W-1:0] done_bytes,
  output logic             err_valid,
  output logic [1:0]       err_code
);
  cbs_state_e       st_q, st_d, next_blk;
  cbs_ecode_e       ec_q, ec_d;
  logic             mode_q, chk_q, last_q;
  logic             done_d, err_d, launch, accept, flush;
  logic             grant, cfg_fail, tmo, blk_end, chk_hit, lane_last;
  logic [CNT_W-1:0] sent_cnt, total;

  assign launch   = (st_q == ST_IDLE) && start;
  assign in_ready = (st_q == ST_XFER);
  assign accept   = in_valid && in_ready;
  assign flush    = accept && (lane_last || in_last);
  assign next_blk = mode_q ? ST_GATE : ST_XFER;

  cbs_credit_gate #(.POLL_CYCLES(POLL_CYCLES), .MAX_POLLS(MAX_POLLS)) u_gate (
    .clk(clk), .rst_n(rst_n), .active(st_q == ST_GATE),
    .credit_val(credit_val), .sent_lo(sent_cnt[7:0]), .cfg_err(cfg_err),
    .grant(grant), .cfg_fail(cfg_fail), .timeout(tmo)
  );

  cbs_packer #(.WORD_BYTES(WORD_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(launch), .accept(accept), .flush(flush),
    .byte_in(in_data), .lane_last(lane_last), .wr_valid(wr_valid), .wr_data(wr_data)
  );

  cbs_blk_track #(
    .BLK_BYTES(BLK_BYTES), .CHK_BYTES(CHK_BYTES), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .clear(launch), .accept(accept), .last(in_last),
    .legacy(!mode_q), .blk_end(blk_end), .chk_hit(chk_hit),
    .sent_cnt(sent_cnt), .total(total)
  );

  always_comb begin
    st_d   = st_q;
    ec_d   = ec_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d = credit_mode ? ST_GATE : ST_XFER;
        ec_d = EC_NONE;
      end
      ST_GATE: begin
        if (grant) begin
          st_d = ST_XFER;
        end else if (cfg_fail) begin
          st_d = ST_IDLE; err_d = 1'b1; ec_d = EC_CFGERR;
        end else if (tmo) begin
          st_d = ST_IDLE; err_d = 1'b1; ec_d = EC_TIMEOUT;
        end
      end
      ST_XFER: if (blk_end) begin
        if (chk_q && chk_hit) begin
          st_d = ST_BCHK;
        end else if (in_last) begin
          if (chk_q) begin
            st_d = ST_FIN;
          end else begin
            st_d = ST_IDLE; done_d = 1'b1;
          end
        end else begin
          st_d = next_blk;
        end
      end
      ST_BCHK: begin
        if (cfg_err) begin
          st_d = ST_IDLE; err_d = 1'b1; ec_d = EC_CFGERR;
        end else begin
          st_d = last_q ? ST_FIN : next_blk;
        end
      end
      ST_FIN: begin
        st_d = ST_IDLE;
        if (cfg_err) begin
          err_d = 1'b1; ec_d = EC_CFGERR;
        end else begin
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ec_q      <= EC_NONE;
      mode_q    <= 1'b0;
      chk_q     <= 1'b0;
      last_q    <= 1'b0;
      done      <= 1'b0;
      err_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      ec_q      <= ec_d;
      done      <= done_d;
      err_valid <= err_d;
      if (launch) begin
        mode_q <= credit_mode;
        chk_q  <= chk_en;
        last_q <= 1'b0;
      end else if (accept && in_last) begin
        last_q <= 1'b1;
      end
    end
  end

  assign done_bytes = total;
  assign err_code   = ec_q;
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             wr_valid,
  input logic             done,
  input logic             err_valid,
  input logic [1:0]       err_code,
  input logic [CNT_W-1:0] sent_cnt
);
  // R10: a session has exactly one outcome at a time
  p_single_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err_valid));

  // R10: completion is a one-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: nothing is accepted once the outcome is reported
  p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_valid) |-> !in_ready);

  // R7: an abort always carries one of the two defined codes
  p_err_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_code == 2'd1 || err_code == 2'd2));

  // R4: a write strobe only follows an accepted byte
  p_write_follows_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(in_valid && in_ready));

  // R2: the block count only steps by one or is cleared
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_cnt != $past(sent_cnt)) |-> (sent_cnt == $past(sent_cnt) + 1'b1 || sent_cnt == '0));
endmodule

bind cfg_block_streamer cbs_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wr_valid(wr_valid), .done(done), .err_valid(err_valid),
  .err_code(err_code), .sent_cnt(sent_cnt)
);

// File: tb/sim_cfg_block_streamer.sv
module sim_cfg_block_streamer;
  localparam int BLK = 16;
  localparam int PC  = 4;
  localparam int MP  = 5;
  localparam int CK  = 32;
  localparam int CW  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, credit_mode = 1'b0, chk_en = 1'b0;
  logic          in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]    in_data = 8'h00, credit_val = 8'h00;
  logic          cfg_err = 1'b0;
  logic          in_ready, wr_valid, done, err_valid;
  logic [31:0]   wr_data;
  logic [CW-1:0] done_bytes;
  logic [1:0]    err_code;

  always #5 clk = ~clk;

  cfg_block_streamer #(
    .BLK_BYTES(BLK), .POLL_CYCLES(PC), .MAX_POLLS(MP), .CHK_BYTES(CK), .CNT_W(CW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .credit_mode(credit_mode), .chk_en(chk_en),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .credit_val(credit_val), .cfg_err(cfg_err), .wr_valid(wr_valid), .wr_data(wr_data),
    .done(done), .done_bytes(done_bytes), .err_valid(err_valid), .err_code(err_code)
  );

  int checks = 0, fails = 0;
  int acc_cnt = 0, stall_cnt = 0, done_cnt = 0, err_cnt = 0, cyc = 0;
  int last_bytes = 0, last_ec = 0;
  logic [31:0] expq[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 37 + s * 59 + 7) & 255);
  endfunction

  // Reference: every write strobe must match the next expected word.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (wr_valid) begin
        if (expq.size() == 0) chk(1'b0, "R4 write with no expected word", wr_data, 0);
        else begin
          logic [31:0] w;
          w = expq.pop_front();
          chk(wr_data == w, "R4/R5 word value", wr_data, w);
        end
      end
      if (in_valid && in_ready) acc_cnt++;
      if (in_valid && !in_ready) stall_cnt++;
      if (done) begin done_cnt++; last_bytes = int'(done_bytes); end
      if (err_valid) begin err_cnt++; last_ec = int'(err_code); end
    end
  end

  task automatic run_image(input int n, input int seed, input bit cmode, input bit ck);
    int d0, e0;
    expq.delete();
    for (int i = 0; i < n; i += 4) begin
      logic [31:0] w;
      w = '0;
      for (int k = 0; k < 4; k++) if (i + k < n) w[8*k +: 8] = pat(i + k, seed);
      expq.push_back(w);
    end
    acc_cnt = 0; stall_cnt = 0;
    d0 = done_cnt; e0 = err_cnt;
    @(posedge clk); #1;
    start = 1'b1; credit_mode = cmode; chk_en = ck;
    while (done_cnt == d0 && err_cnt == e0) begin
      @(posedge clk); #1;
      start = 1'b0;
      if (acc_cnt < n) begin
        in_valid = 1'b1; in_data = pat(acc_cnt, seed); in_last = (acc_cnt == n - 1);
      end else begin
        in_valid = 1'b0; in_last = 1'b0;
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int d0, e0, t0, lat;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R10 reset in_ready", in_ready, 0);
    chk(wr_valid == 1'b0, "R10 reset wr_valid", wr_valid, 0);
    chk(done == 1'b0, "R10 reset done", done, 0);
    chk(err_valid == 1'b0, "R10 reset err_valid", err_valid, 0);

    // Legacy mode, error flag high but checking off: must finish, no stalls.
    cfg_err = 1'b1;
    d0 = done_cnt; e0 = err_cnt;
    run_image(11, 1, 1'b0, 1'b0);
    chk(done_cnt == d0 + 1, "R9 done after 11 bytes", done_cnt - d0, 1);
    chk(err_cnt == e0, "R9 cfg_err ignored", err_cnt - e0, 0);
    chk(last_bytes == 11, "R9 done_bytes", last_bytes, 11);
    chk(stall_cnt == 0, "R3 legacy never stalls", stall_cnt, 0);
    chk(expq.size() == 0, "R5 all words incl. 3-byte tail written", expq.size(), 0);
    run_image(13, 2, 1'b0, 1'b0);
    chk(last_bytes == 13, "R9 done_bytes 13", last_bytes, 13);
    chk(expq.size() == 0, "R5 1-byte tail written", expq.size(), 0);
    cfg_err = 1'b0;

    // Credit mode: stall at start until credit differs from count 0.
    credit_val = 8'd0;
    d0 = done_cnt;
    fork
      run_image(38, 3, 1'b1, 1'b0);
      begin
        repeat (10) @(posedge clk);
        #2;
        chk(acc_cnt == 0, "R1 no byte before credit", acc_cnt, 0);
        credit_val = 8'd3;
      end
    join
    chk(done_cnt == d0 + 1, "R2 credit session done", done_cnt - d0, 1);
    chk(last_bytes == 38, "R2 done_bytes 38", last_bytes, 38);
    chk(expq.size() == 0, "R4 credit words written", expq.size(), 0);

    // Count must restart at zero: with credit 3, blocks 0..2 all granted.
    d0 = done_cnt;
    run_image(38, 4, 1'b1, 1'b0);
    chk(done_cnt == d0 + 1, "R1 count cleared at start", done_cnt - d0, 1);

    // Stall from the first read until timeout.
    credit_val = 8'd0;
    e0 = err_cnt;
    run_image(16, 5, 1'b1, 1'b0);
    chk(err_cnt == e0 + 1 && last_ec == 1, "R7 timeout code", last_ec, 1);
    chk(acc_cnt == 0, "R7 nothing accepted", acc_cnt, 0);
    chk(stall_cnt >= (MP - 1) * PC + 1 && stall_cnt <= MP * PC + 3, "R7 timeout window",
        stall_cnt, (MP - 1) * PC + 1);

    // Config error seen on the first stalled read.
    cfg_err = 1'b1;
    e0 = err_cnt;
    run_image(16, 6, 1'b1, 1'b0);
    chk(err_cnt == e0 + 1 && last_ec == 2, "R6 immediate cfg error code", last_ec, 2);
    chk(acc_cnt == 0, "R6 nothing accepted", acc_cnt, 0);
    cfg_err = 1'b0;

    // Config error raised mid-stall is caught at the next read.
    e0 = err_cnt;
    lat = 0;
    fork
      run_image(16, 7, 1'b1, 1'b0);
      begin
        repeat (7) @(posedge clk);
        #2;
        cfg_err = 1'b1;
        t0 = cyc;
        wait (err_cnt > e0);
        lat = cyc - t0;
      end
    join
    chk(last_ec == 2, "R6 mid-stall cfg error code", last_ec, 2);
    chk(lat <= PC + 2, "R6 error latency within one poll", lat, PC + 2);
    cfg_err = 1'b0;

    // 8-bit wrap: credit fixed 0 after block 0, block 256 stalls.
    credit_val = 8'd1;
    e0 = err_cnt;
    fork
      run_image(257 * BLK, 8, 1'b1, 1'b0);
      begin
        wait (acc_cnt >= BLK);
        credit_val = 8'd0;
      end
    join
    chk(acc_cnt == 256 * BLK, "R2 wrap stall point", acc_cnt, 256 * BLK);
    chk(err_cnt == e0 + 1 && last_ec == 1, "R2 wrap ends in timeout", last_ec, 1);

    // Optional checking, clean image.
    credit_val = 8'hFF;
    d0 = done_cnt;
    run_image(64, 9, 1'b1, 1'b1);
    chk(done_cnt == d0 + 1 && last_bytes == 64, "R8 checked image done", last_bytes, 64);

    // Error flag rises after byte 40: caught at the 64-byte boundary.
    d0 = done_cnt; e0 = err_cnt;
    fork
      run_image(64, 10, 1'b1, 1'b1);
      begin
        wait (acc_cnt >= 40);
        cfg_err = 1'b1;
      end
    join
    chk(err_cnt == e0 + 1 && last_ec == 2, "R8 boundary check code", last_ec, 2);
    chk(done_cnt == d0, "R8 no done on boundary error", done_cnt - d0, 0);
    chk(acc_cnt == 64, "R8 bytes before boundary abort", acc_cnt, 64);
    cfg_err = 1'b0;

    // End-of-image check in legacy mode, no boundary reached.
    cfg_err = 1'b1;
    d0 = done_cnt; e0 = err_cnt;
    run_image(20, 11, 1'b0, 1'b1);
    chk(err_cnt == e0 + 1 && last_ec == 2, "R8 end check code", last_ec, 2);
    chk(acc_cnt == 20, "R8 all bytes before end check", acc_cnt, 20);
    chk(done_cnt == d0, "R8 no done on end error", done_cnt - d0, 0);
    cfg_err = 1'b0;

    @(negedge clk);
    chk(in_ready == 1'b0 && wr_valid == 1'b0, "R10 idle after sessions", in_ready, 0);
    summary();
    $finish;
  end
endmodule